// File: doc/BRIEF.md
# Shared Sequential Multiplier and Restoring Divider

This block computes either the full-width product or the quotient and remainder of two unsigned W-bit operands. Both operations run on one set of three registers: an accumulator P, an operand/result register A and an operand register B. Multiplication moves the (P,A) pair right, adding B into P whenever the bit about to leave A is a one. Division moves the pair left and makes a trial subtraction of B from P. When the trial result is negative, the old P is kept and a zero quotient bit is written; otherwise the difference is kept and a one is written. Each step takes one clock cycle, so any operation finishes in W steps.

A client presents the operands and the operation select, then pulses `start` while the unit is idle. The unit raises `busy` for exactly W cycles and then raises `done` for one cycle. From that cycle on, `res_hi`/`res_lo` hold the product halves, or the remainder and quotient, until the next accepted start. The controller is a four-state machine:
- `ST_IDLE`: waiting for a start.
- `ST_MUL`: a multiply step every cycle.
- `ST_DIV`: a divide step every cycle.
- `ST_DONE`: results valid, `done` high.

The transitions are:
- IDLE→MUL or IDLE→DIV on an accepted start, chosen by `op_div`.
- MUL→DONE and DIV→DONE after the W-th step.
- DONE→MUL or DONE→DIV on a start in the done cycle.
- DONE→IDLE otherwise.

Top module: `seqmd_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the unit goes idle. `busy`, `done`, `div_zero`, `res_hi` and `res_lo` all read 0 afterwards.
- R2: A `start` is accepted at a rising edge when `busy` is 0, including the cycle in which `done` is 1. On acceptance, `opa`, `opb` and `op_div` are captured. `busy` is 1 from the next cycle for exactly W consecutive cycles.
- R3: `done` is 1 for exactly one cycle, the cycle directly after the last busy cycle. `busy` is 0 in that cycle.
- R4: With `op_div`=0 the result is the product: {`res_hi`,`res_lo`} equals `opa`×`opb` as a 2W-bit value, with the low half in `res_lo`.
- R5: With `op_div`=1 and a nonzero divisor, `res_lo` is `opa`/`opb` and `res_hi` is `opa` mod `opb`.
- R6: A `start` while `busy` is 1 is ignored, and so are changes to the operand inputs after acceptance. The operation in flight keeps its captured operands and its W-cycle length, and no extra result is produced.
- R7: With `op_div`=1 and `opb`=0, the normal W steps run. The result is `res_lo` all ones and `res_hi` equal to `opa`, and `div_zero` is 1. In every other completed operation `div_zero` is 0.
- R8: After `done`, the values of `res_hi`, `res_lo` and `div_zero` stay unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start request, sampled when not busy |
| op_div | input | 1 | Operation select: 0 multiply, 1 divide |
| opa | input | W | Multiplier or dividend |
| opb | input | W | Multiplicand or divisor |
| res_hi | output | W | Product high half, or remainder |
| res_lo | output | W | Product low half, or quotient |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| div_zero | output | 1 | Last division had a zero divisor |

## Verification
The checker assumes that the inputs matter only in the cycle a start is accepted. It therefore captures the operands and select at that edge and checks the finished result against arithmetic on those captured values. It also assumes W is at least 2, so that the divide shift has a lower part. The bench drives every input on the falling edge. It changes the operand inputs right after each accepted start and issues a start in the middle of one operation, so that the captured operands are what the design is judged against. Back-to-back operations start only in the done cycle, when `busy` is already low.

// File: rtl/seqmd_pkg.sv
package seqmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2,
        ST_DONE = 2'd3
    } md_state_e;

endpackage

// File: rtl/seqmd_step.sv
// Combinational single step: shift-right with conditional add, or
// shift-left with a restoring trial subtraction.
module seqmd_step #(
    parameter int W = 8
) (
    input  logic         div_mode,
    input  logic [W-1:0] p_cur,
    input  logic [W-1:0] a_cur,
    input  logic [W-1:0] b_cur,
    output logic [W-1:0] p_nxt,
    output logic [W-1:0] a_nxt
);
    logic [W:0] add_sum;
    logic [W:0] shl_p;
    logic [W:0] trial;
    logic       trial_neg;

    always_comb begin
        add_sum   = {1'b0, p_cur} + {1'b0, (a_cur[0] ? b_cur : {W{1'b0}})};
        shl_p     = {p_cur, a_cur[W-1]};
        trial     = shl_p - {1'b0, b_cur};
        trial_neg = trial[W];
        if (div_mode) begin
            p_nxt = trial_neg ? shl_p[W-1:0] : trial[W-1:0];
            a_nxt = {a_cur[W-2:0], ~trial_neg};
        end else begin
            p_nxt = add_sum[W:1];
            a_nxt = {add_sum[0], a_cur[W-1:1]};
        end
    end
endmodule

// File: rtl/seqmd_ctrl.sv
module seqmd_ctrl
    import seqmd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic op_div,
    output logic load,
    output logic step,
    output logic div_mode,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(W + 1);

    md_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          accept;
    logic          last_step;

    assign accept    = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign last_step = (cnt_q == CW'(W - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = op_div ? ST_DIV : ST_MUL;
            ST_MUL:  if (last_step) state_d = ST_DONE;
            ST_DIV:  if (last_step) state_d = ST_DONE;
            ST_DONE: state_d = accept ? (op_div ? ST_DIV : ST_MUL) : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept)
                cnt_q <= '0;
            else if (step)
                cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        load     = accept;
        step     = 1'b0;
        div_mode = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_MUL:  begin step = 1'b1; busy = 1'b1; end
            ST_DIV:  begin step = 1'b1; busy = 1'b1; div_mode = 1'b1; end
            ST_DONE: done = 1'b1;
        endcase
    end
endmodule

// File: rtl/seqmd_datapath.sv
module seqmd_datapath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         div_mode,
    input  logic         op_div,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] p_out,
    output logic [W-1:0] a_out,
    output logic         dz_out
);
    logic [W-1:0] p_q, a_q, b_q;
    logic [W-1:0] p_nx, a_nx;
    logic         dz_q;

    seqmd_step #(.W(W)) step_i (
        .div_mode (div_mode),
        .p_cur    (p_q),
        .a_cur    (a_q),
        .b_cur    (b_q),
        .p_nxt    (p_nx),
        .a_nxt    (a_nx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q  <= '0;
            a_q  <= '0;
            b_q  <= '0;
            dz_q <= 1'b0;
        end else if (load) begin
            p_q  <= '0;
            a_q  <= opa;
            b_q  <= opb;
            dz_q <= op_div && (opb == '0);
        end else if (step) begin
            p_q <= p_nx;
            a_q <= a_nx;
        end
    end

    assign p_out  = p_q;
    assign a_out  = a_q;
    assign dz_out = dz_q;
endmodule

// File: rtl/seqmd_unit.sv
module seqmd_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op_div,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo,
    output logic         busy,
    output logic         done,
    output logic         div_zero
);
    logic load, step, div_mode;

    seqmd_ctrl #(.W(W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_div   (op_div),
        .load     (load),
        .step     (step),
        .div_mode (div_mode),
        .busy     (busy),
        .done     (done)
    );

    seqmd_datapath #(.W(W)) dp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .div_mode (div_mode),
        .op_div   (op_div),
        .opa      (opa),
        .opb      (opb),
        .p_out    (res_hi),
        .a_out    (res_lo),
        .dz_out   (div_zero)
    );
endmodule

// File: rtl/seqmd_chk.sv
module seqmd_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         op_div,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic [W-1:0] res_hi,
    input logic [W-1:0] res_lo,
    input logic         busy,
    input logic         done,
    input logic         div_zero
);
    logic [W-1:0] cap_a, cap_b;
    logic         cap_div;
    int           bcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a   <= '0;
            cap_b   <= '0;
            cap_div <= 1'b0;
            bcnt    <= 0;
        end else if (start && !busy) begin
            cap_a   <= opa;
            cap_b   <= opb;
            cap_div <= op_div;
            bcnt    <= 0;
        end else if (busy) begin
            bcnt <= bcnt + 1;
        end
    end

    assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt < W));

    assert_done_after_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bcnt == W));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_mul_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_div) |->
            ({res_hi, res_lo} == ({{W{1'b0}}, cap_a} * {{W{1'b0}}, cap_b})));

    assert_div_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_div && cap_b != '0) |->
            (res_lo == cap_a / cap_b && res_hi == cap_a % cap_b));

    assert_dz_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (div_zero == (cap_div && cap_b == '0)));

    assert_dz_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (res_lo == {W{1'b1}} && res_hi == cap_a));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({res_hi, res_lo, div_zero}));
endmodule

bind seqmd_unit seqmd_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_div   (op_div),
    .opa      (opa),
    .opb      (opb),
    .res_hi   (res_hi),
    .res_lo   (res_lo),
    .busy     (busy),
    .done     (done),
    .div_zero (div_zero)
);

// File: tb/seqmd_unit_tb_top.sv
module seqmd_unit_tb_top;
    localparam int W = 8;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op_div = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] res_hi, res_lo;
    logic         busy, done, div_zero;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        logic         dz;
        string        tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    seqmd_unit #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
        .opa(opa), .opb(opb), .res_hi(res_hi), .res_lo(res_lo),
        .busy(busy), .done(done), .div_zero(div_zero)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Monitor: compare each done pulse with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R6 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(res_hi == e.hi, {e.tag, " res_hi"}, res_hi, e.hi);
                chk(res_lo == e.lo, {e.tag, " res_lo"}, res_lo, e.lo);
                chk(div_zero == e.dz, {e.tag, " R7 div_zero"}, div_zero, e.dz);
            end
        end
    end

    // Driver: called just after a falling edge with busy low.
    task automatic issue(input logic d, input logic [W-1:0] a, input logic [W-1:0] b,
                         input string tag);
        exp_t e;
        logic [2*W-1:0] prod;
        e.tag = tag;
        e.dz  = 1'b0;
        if (d) begin
            if (b == '0) begin
                e.lo = '1; e.hi = a; e.dz = 1'b1;
            end else begin
                e.lo = a / b; e.hi = a % b;
            end
        end else begin
            prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
            e.hi = prod[2*W-1:W];
            e.lo = prod[W-1:0];
        end
        sb.push_back(e);
        op_div = d; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        opa = ~a; opb = ~b;   // R6: later operand changes must not matter
        chk(busy == 1'b1, "R2 busy after accept", busy, 1);
    endtask

    // Count busy cycles; returns at the falling edge where done is expected.
    task automatic finish_op(input bit poke_start);
        int n = 0;
        while (busy && n < 4 * W) begin
            n++;
            if (poke_start && n == 3) begin
                start = 1'b1; op_div = ~op_div; opa = 8'h11; opb = 8'h03;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(n == W, "R2 busy length", n, W);
        chk(done == 1'b1, "R3 done after last step", done, 1);
        chk(busy == 1'b0, "R3 busy low with done", busy, 0);
    endtask

    task automatic run(input logic d, input logic [W-1:0] a, input logic [W-1:0] b,
                       input string tag);
        issue(d, a, b, tag);
        finish_op(1'b0);
        @(negedge clk);
        chk(done == 1'b0, "R3 done single cycle", done, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        logic [W-1:0] h_hi, h_lo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(div_zero == 1'b0, "R1 div_zero", div_zero, 0);
        chk(res_hi == '0, "R1 res_hi", res_hi, 0);
        chk(res_lo == '0, "R1 res_lo", res_lo, 0);

        run(1'b0, 8'd0,   8'd77,  "R4 zero times x");
        run(1'b0, 8'd1,   8'd200, "R4 one times x");
        run(1'b0, 8'hFF,  8'hFF,  "R4 max times max");
        run(1'b0, 8'hA5,  8'h3C,  "R4 mixed");
        run(1'b0, 8'h80,  8'h02,  "R4 carry into high");

        run(1'b1, 8'd200, 8'd1,   "R5 divide by one");
        run(1'b1, 8'd5,   8'd9,   "R5 small by large");
        run(1'b1, 8'hFF,  8'hFF,  "R5 equal");
        run(1'b1, 8'd250, 8'd7,   "R5 mixed");
        run(1'b1, 8'hFF,  8'h80,  "R5 top divisor");

        run(1'b1, 8'd123, 8'd0,   "R7 divide by zero");
        run(1'b1, 8'd0,   8'd0,   "R7 zero by zero");
        run(1'b0, 8'd3,   8'd0,   "R7 multiply by zero no flag");

        // R6: start poked during busy with other operands and select
        issue(1'b0, 8'd13, 8'd11, "R6 in-flight multiply");
        finish_op(1'b1);
        @(negedge clk);
        chk(done == 1'b0, "R6 no restart", done, 0);
        chk(busy == 1'b0, "R6 no extra busy", busy, 0);

        // R8: results held while idle with changing operand inputs
        h_hi = res_hi; h_lo = res_lo;
        opa = 8'h5A; opb = 8'hC3; op_div = 1'b1;
        repeat (4) @(negedge clk);
        chk(res_hi == h_hi, "R8 res_hi held", res_hi, h_hi);
        chk(res_lo == h_lo, "R8 res_lo held", res_lo, h_lo);

        // R2: back-to-back starts in the done cycle
        issue(1'b1, 8'd100, 8'd6, "R2 back-to-back first");
        finish_op(1'b0);
        issue(1'b0, 8'd17, 8'd15, "R2 back-to-back second");
        finish_op(1'b0);
        issue(1'b1, 8'd99, 8'd0, "R2 back-to-back third R7");
        finish_op(1'b0);
        @(negedge clk);
        chk(done == 1'b0, "R3 done single cycle", done, 0);

        repeat (2) @(negedge clk);
        chk(sb.size() == 0, "R6 all results seen", sb.size(), 0);
        summary();
    end
endmodule